// File: doc/BRIEF.md
# Semaphore-Driven DMA Command Sequencer

This block is one DMA channel engine. Software leaves command descriptors in memory, each one linked to the next, and then writes a count of owed commands into a semaphore register. The engine reads each descriptor through a single-outstanding word-read port and runs the command. The data movement is modelled as a busy window of fixed length. When the command ends, the engine raises a sticky completion flag. It then lowers the semaphore if the command asks for that.

The semaphore decides whether the channel keeps running. There is no end-of-list marker and no total length. The engine stops as soon as the count reaches zero. While the channel runs, software can add more commands by writing to the semaphore, and the written value is added to the count that remains. A command that is not chained parks the engine until software supplies a new descriptor address.

Top module: `sdq_channel`

## Requirements
- R1: In idle, a semaphore write with a nonzero value starts the engine. It fetches first from the address held in the next-descriptor register. A write of zero, or a next-descriptor write on its own, starts nothing and issues no read request.
- R2: A descriptor at word address A uses two words. Word A holds the link address. Word A+1 holds the control word: bit 0 is chain, bit 1 is decrement, and bits 31:2 are the length. The engine reads word A and then word A+1, with one rd_req cycle for each word.
- R3: Once the control word arrives, exec_busy is high for exactly XFER_LAT cycles (default 4), and exec_len shows the length field of the command.
- R4: When a command completes, the semaphore drops by one only if the decrement bit of that command is 1.
- R5: If the semaphore is zero after a completion, the engine returns to idle and fetches nothing more, even when the chain bit is set.
- R6: If the semaphore is nonzero after a completion and the chain bit is 1, the next fetch is from the link address of the command that just finished.
- R7: If the semaphore is nonzero after a completion and the chain bit is 0, the engine stays busy and issues no read request until a next-descriptor write arrives. It then fetches from the written address.
- R8: A semaphore write adds its value to the current count. If the write falls in the same cycle as a decrement, the result is count + value - 1.
- R9: The count saturates: the result of count + value - decrement is clamped to 255.
- R10: sema_count shows the number of commands still owed, and it reads 0 whenever busy is low.
- R11: cmplt_flag is set by every completion and stays set until cmplt_clr is asserted. If a completion and a clear fall in the same cycle, the set wins.
- R12: A chan_rst pulse returns the engine to idle by the next cycle, with the semaphore at 0, cmplt_flag at 0 and no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset |
| nxt_addr_we | input | 1 | Write strobe for the next-descriptor address |
| nxt_addr_wdata | input | DATA_W | Next-descriptor address value |
| sema_we | input | 1 | Semaphore write strobe (the value is added) |
| sema_wdata | input | SEMA_W | Value added to the semaphore |
| cmplt_clr | input | 1 | Clears the completion flag |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | DATA_W | Read response word |
| rd_req | output | 1 | One-cycle word read request |
| rd_addr | output | DATA_W | Word address of the read |
| sema_count | output | SEMA_W | Current semaphore count |
| busy | output | 1 | Engine is not idle |
| cmplt_flag | output | 1 | Sticky command-complete status |
| exec_busy | output | 1 | Modelled data movement in progress |
| exec_len | output | DATA_W-2 | Length field of the running command |

## Verification
The hardest case to reach from the ports is a semaphore write that lands in the exact cycle in which a command completes. Both the addition and the decrement must then resolve in one update. The stimulus waits for the rising edge of exec_busy, counts XFER_LAT-1 further cycles, and drives the write in the final execute cycle. It then expects count + value - 1. The same run ends on an unchained command with a nonzero count, which leaves the engine parked. That parked state is then used to push the count into saturation, and after that to check the channel reset.

// File: rtl/sdq_pkg.sv
package sdq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_PTR = 3'd1,
        ST_WT_PTR = 3'd2,
        ST_RD_CTL = 3'd3,
        ST_WT_CTL = 3'd4,
        ST_EXEC   = 3'd5,
        ST_HALT   = 3'd6
    } seq_state_e;

    // control word field positions
    localparam int CTL_CHAIN_BIT = 0;
    localparam int CTL_DEC_BIT   = 1;
    localparam int CTL_LEN_LSB   = 2;

endpackage

// File: rtl/sdq_sema_ctr.sv
module sdq_sema_ctr #(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [SEMA_W-1:0] add_val,
    input  logic              dec_en,
    output logic [SEMA_W-1:0] count_q,
    output logic [SEMA_W-1:0] count_next
);
    localparam int SUM_W = SEMA_W + 2;
    localparam logic [SUM_W-1:0] CAP = SUM_W'((1 << SEMA_W) - 1);

    typedef struct packed {
        logic [SEMA_W-1:0] count;
    } sema_s;

    sema_s d, q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        d   = q;
        sum = {2'b00, q.count}
            + (add_en ? {2'b00, add_val} : '0)
            - (dec_en ? SUM_W'(1) : '0);
        if (sum[SUM_W-1]) begin
            d.count = '0;                     // borrow: never below zero
        end else if (sum > CAP) begin
            d.count = CAP[SEMA_W-1:0];        // saturate on addition
        end else begin
            d.count = sum[SEMA_W-1:0];
        end
        if (clr) begin
            d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_q    = q.count;
    assign count_next = d.count;

endmodule

// File: rtl/sdq_xfer_timer.sv
module sdq_xfer_timer #(
    parameter int XFER_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int CNT_W = $clog2(XFER_LAT + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(XFER_LAT - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.active = 1'b1;
            d.cnt    = LOAD;
        end else if (q.active) begin
            if (q.cnt == '0) begin
                d.active = 1'b0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        if (clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign active = q.active;
    assign done   = q.active && (q.cnt == '0);

endmodule

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
    import sdq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              nxt_we,
    input  logic [DATA_W-1:0] nxt_wdata,
    input  logic              sema_we,
    input  logic [SEMA_W-1:0] sema_wdata,
    input  logic [SEMA_W-1:0] sema_next,
    input  logic              cmplt_clr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              xfer_done,
    output logic              rd_req,
    output logic [DATA_W-1:0] rd_addr,
    output logic              xfer_start,
    output logic              dec_en,
    output logic              busy,
    output logic              cmplt,
    output logic [DATA_W-3:0] exec_len
);
    localparam int LEN_W = DATA_W - CTL_LEN_LSB;

    typedef struct packed {
        seq_state_e        st;
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] nxt_sw;
        logic [DATA_W-1:0] link;
        logic              chain;
        logic              dec;
        logic [LEN_W-1:0]  len;
        logic              flag;
    } ctrl_s;

    ctrl_s d, q;

    // decrement request is kept apart from the next-state logic
    assign dec_en = (q.st == ST_EXEC) && xfer_done && q.dec;

    always_comb begin
        d          = q;
        rd_req     = 1'b0;
        rd_addr    = q.ptr;
        xfer_start = 1'b0;

        if (nxt_we) begin
            d.nxt_sw = nxt_wdata;
        end
        if (cmplt_clr) begin
            d.flag = 1'b0;
        end

        case (q.st)
            ST_IDLE: begin
                if (sema_we && (sema_wdata != '0)) begin
                    d.st  = ST_RD_PTR;
                    d.ptr = q.nxt_sw;
                end
            end
            ST_RD_PTR: begin
                rd_req  = 1'b1;
                rd_addr = q.ptr;
                d.st    = ST_WT_PTR;
            end
            ST_WT_PTR: begin
                if (rd_valid) begin
                    d.link = rd_data;
                    d.st   = ST_RD_CTL;
                end
            end
            ST_RD_CTL: begin
                rd_req  = 1'b1;
                rd_addr = q.ptr + DATA_W'(1);
                d.st    = ST_WT_CTL;
            end
            ST_WT_CTL: begin
                if (rd_valid) begin
                    d.chain    = rd_data[CTL_CHAIN_BIT];
                    d.dec      = rd_data[CTL_DEC_BIT];
                    d.len      = rd_data[DATA_W-1:CTL_LEN_LSB];
                    d.st       = ST_EXEC;
                    xfer_start = 1'b1;
                end
            end
            ST_EXEC: begin
                if (xfer_done) begin
                    d.flag = 1'b1;
                    if (sema_next == '0) begin
                        d.st = ST_IDLE;
                    end else if (q.chain) begin
                        d.st  = ST_RD_PTR;
                        d.ptr = q.link;
                    end else begin
                        d.st = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (nxt_we) begin
                    d.st  = ST_RD_PTR;
                    d.ptr = nxt_wdata;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (chan_rst) begin
            d.st   = ST_IDLE;
            d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign cmplt    = q.flag;
    assign exec_len = q.len;

endmodule

// File: rtl/sdq_channel.sv
module sdq_channel #(
    parameter int DATA_W   = 32,
    parameter int SEMA_W   = 8,
    parameter int XFER_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              nxt_addr_we,
    input  logic [DATA_W-1:0] nxt_addr_wdata,
    input  logic              sema_we,
    input  logic [SEMA_W-1:0] sema_wdata,
    input  logic              cmplt_clr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [DATA_W-1:0] rd_addr,
    output logic [SEMA_W-1:0] sema_count,
    output logic              busy,
    output logic              cmplt_flag,
    output logic              exec_busy,
    output logic [DATA_W-3:0] exec_len
);
    logic              dec_en;
    logic              xfer_start;
    logic              xfer_done;
    logic [SEMA_W-1:0] sema_next;

    sdq_sema_ctr #(.SEMA_W(SEMA_W)) u_sema (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (chan_rst),
        .add_en     (sema_we),
        .add_val    (sema_wdata),
        .dec_en     (dec_en),
        .count_q    (sema_count),
        .count_next (sema_next)
    );

    sdq_xfer_timer #(.XFER_LAT(XFER_LAT)) u_xfer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (chan_rst),
        .start  (xfer_start),
        .active (exec_busy),
        .done   (xfer_done)
    );

    sdq_ctrl #(.DATA_W(DATA_W), .SEMA_W(SEMA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_rst   (chan_rst),
        .nxt_we     (nxt_addr_we),
        .nxt_wdata  (nxt_addr_wdata),
        .sema_we    (sema_we),
        .sema_wdata (sema_wdata),
        .sema_next  (sema_next),
        .cmplt_clr  (cmplt_clr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .xfer_done  (xfer_done),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .xfer_start (xfer_start),
        .dec_en     (dec_en),
        .busy       (busy),
        .cmplt      (cmplt_flag),
        .exec_len   (exec_len)
    );

endmodule

// File: rtl/sdq_channel_chk.sv
module sdq_channel_chk #(
    parameter int SEMA_W   = 8,
    parameter int XFER_LAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_rst,
    input logic              busy,
    input logic              rd_req,
    input logic [SEMA_W-1:0] sema_count,
    input logic              cmplt_flag,
    input logic              cmplt_clr,
    input logic              exec_busy
);
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (exec_busy) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    assert_exec_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_busy |-> (run_q < 16'(XFER_LAT)));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sema_count == '0));

    assert_no_idle_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);

    assert_flag_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmplt_flag && !cmplt_clr && !chan_rst) |=> cmplt_flag);

    assert_chan_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (!busy && (sema_count == '0) && !cmplt_flag));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_rst |=> (({1'b0, sema_count} + 1'b1) >= {1'b0, $past(sema_count)}));

endmodule

bind sdq_channel sdq_channel_chk #(.SEMA_W(SEMA_W), .XFER_LAT(XFER_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_rst   (chan_rst),
    .busy       (busy),
    .rd_req     (rd_req),
    .sema_count (sema_count),
    .cmplt_flag (cmplt_flag),
    .cmplt_clr  (cmplt_clr),
    .exec_busy  (exec_busy)
);

// File: tb/sdq_channel_test.sv
`timescale 1ns/1ps
module sdq_channel_test;
    localparam int DATA_W   = 32;
    localparam int SEMA_W   = 8;
    localparam int XFER_LAT = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chan_rst = 1'b0;
    logic              nxt_addr_we = 1'b0;
    logic [DATA_W-1:0] nxt_addr_wdata = '0;
    logic              sema_we = 1'b0;
    logic [SEMA_W-1:0] sema_wdata = '0;
    logic              cmplt_clr = 1'b0;
    logic              rd_valid = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              rd_req;
    logic [DATA_W-1:0] rd_addr;
    logic [SEMA_W-1:0] sema_count;
    logic              busy;
    logic              cmplt_flag;
    logic              exec_busy;
    logic [DATA_W-3:0] exec_len;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [31:0] mem [64];

    sdq_channel #(.DATA_W(DATA_W), .SEMA_W(SEMA_W), .XFER_LAT(XFER_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .nxt_addr_we(nxt_addr_we), .nxt_addr_wdata(nxt_addr_wdata),
        .sema_we(sema_we), .sema_wdata(sema_wdata), .cmplt_clr(cmplt_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .sema_count(sema_count), .busy(busy), .cmplt_flag(cmplt_flag),
        .exec_busy(exec_busy), .exec_len(exec_len)
    );

    initial forever #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // memory responder: one word, one cycle after the request
    initial forever begin
        @(negedge clk);
        rd_valid = 1'b0;
        if (rd_req) begin
            int a;
            a = int'(rd_addr[5:0]);
            @(negedge clk);
            rd_valid = 1'b1;
            rd_data  = mem[a];
        end
    end

    // scoreboard monitor: each command start is compared with the queue
    initial begin
        logic prev = 1'b0;
        int run = 0;
        forever begin
            @(negedge clk);
            if (exec_busy && !prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", int'(exec_len), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(exec_len) == e, "R6", int'(exec_len), e);
                end
            end
            if (exec_busy) run++;
            if (!exec_busy && prev) begin
                chk(run == XFER_LAT, "R3", run, XFER_LAT);
                run = 0;
            end
            prev = exec_busy;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic put_desc(input int a, input int nxt, input bit chain, input bit dec, input int len);
        mem[a]   = 32'(nxt);
        mem[a+1] = {len[29:0], dec, chain};
    endtask

    task automatic expect_cmd(input int len);
        exp_q.push_back(len);
    endtask

    task automatic nxt_wr(input int a);
        nxt_addr_we = 1'b1; nxt_addr_wdata = 32'(a);
        @(negedge clk);
        nxt_addr_we = 1'b0;
    endtask

    task automatic sema_wr(input int v);
        sema_we = 1'b1; sema_wdata = 8'(v);
        @(negedge clk);
        sema_we = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, req, int'(busy), 0);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic wait_exec_rise();
        do @(negedge clk); while (!exec_busy);
    endtask

    task automatic wait_exec_fall();
        do @(negedge clk); while (exec_busy);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!busy && !rd_req, "R12", int'(busy), 0);
        chk(sema_count == 0, "R10", int'(sema_count), 0);
        chk(!cmplt_flag, "R11", int'(cmplt_flag), 0);

        // R1: address write alone and zero semaphore write do not start
        begin
            bit seen = 1'b0;
            nxt_wr(8);
            sema_wr(0);
            repeat (6) begin
                @(negedge clk);
                if (busy || rd_req) seen = 1'b1;
            end
            chk(!seen, "R1", int'(seen), 0);
        end

        // R1 R2 R4 R6: three chained commands with decrement
        put_desc(8, 16, 1, 1, 'h101);
        put_desc(16, 24, 1, 1, 'h102);
        put_desc(24, 8, 0, 1, 'h103);
        expect_cmd('h101); expect_cmd('h102); expect_cmd('h103);
        nxt_wr(8);
        sema_wr(3);
        chk(sema_count == 3, "R10", int'(sema_count), 3);
        wait_exec_rise();
        wait_exec_fall();
        chk(sema_count == 2, "R4", int'(sema_count), 2);
        wait_idle("R1");
        chk(sema_count == 0, "R10", int'(sema_count), 0);
        chk(cmplt_flag, "R11", int'(cmplt_flag), 1);

        // R11: clear and hold
        cmplt_clr = 1'b1;
        @(negedge clk);
        cmplt_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk(!cmplt_flag, "R11", int'(cmplt_flag), 0);

        // R5: semaphore of one stops a looping chain after one command
        put_desc(8, 16, 1, 1, 'h201);
        put_desc(16, 24, 1, 1, 'h202);
        put_desc(24, 8, 1, 1, 'h203);
        expect_cmd('h201);
        nxt_wr(8);
        sema_wr(1);
        wait_idle("R5");
        repeat (10) @(negedge clk);
        chk(!busy && sema_count == 0, "R5", int'(sema_count), 0);

        // R4: command without decrement flag does not consume the count
        put_desc(8, 16, 1, 1, 'h301);
        put_desc(16, 24, 1, 0, 'h302);
        put_desc(24, 8, 0, 1, 'h303);
        expect_cmd('h301); expect_cmd('h302); expect_cmd('h303);
        nxt_wr(8);
        sema_wr(2);
        wait_idle("R4");
        chk(sema_count == 0, "R4", int'(sema_count), 0);

        // R7: unchained command with count left parks the engine
        put_desc(32, 8, 0, 1, 'h501);
        put_desc(40, 8, 0, 1, 'h502);
        expect_cmd('h501);
        nxt_wr(32);
        sema_wr(2);
        wait_exec_rise();
        wait_exec_fall();
        begin
            bit req_seen = 1'b0;
            repeat (8) begin
                @(negedge clk);
                if (rd_req || !busy) req_seen = 1'b1;
            end
            chk(!req_seen, "R7", int'(req_seen), 0);
        end
        chk(sema_count == 1, "R7", int'(sema_count), 1);
        chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
        expect_cmd('h502);
        nxt_wr(40);
        wait_idle("R7");

        // R8: append while running
        put_desc(8, 16, 1, 1, 'h601);
        put_desc(16, 24, 1, 1, 'h602);
        put_desc(24, 8, 0, 1, 'h603);
        expect_cmd('h601); expect_cmd('h602); expect_cmd('h603);
        nxt_wr(8);
        sema_wr(1);
        wait_exec_rise();
        sema_wr(2);
        chk(sema_count == 3, "R8", int'(sema_count), 3);
        wait_idle("R8");

        // R8 same-cycle add and decrement, then R9 saturation, then R12
        put_desc(8, 16, 1, 1, 'h701);
        put_desc(16, 8, 0, 1, 'h702);
        expect_cmd('h701); expect_cmd('h702);
        nxt_wr(8);
        sema_wr(2);
        wait_exec_rise();
        repeat (XFER_LAT - 1) @(negedge clk);
        sema_wr(5);
        chk(sema_count == 6, "R8", int'(sema_count), 6);
        wait_exec_rise();
        wait_exec_fall();
        repeat (3) @(negedge clk);
        chk(busy && sema_count == 5, "R7", int'(sema_count), 5);
        sema_wr(250);
        chk(sema_count == 255, "R9", int'(sema_count), 255);
        sema_wr(3);
        chk(sema_count == 255, "R9", int'(sema_count), 255);
        chan_rst = 1'b1;
        @(negedge clk);
        chan_rst = 1'b0;
        chk(!busy && !rd_req, "R12", int'(busy), 0);
        chk(sema_count == 0, "R12", int'(sema_count), 0);
        chk(!cmplt_flag, "R12", int'(cmplt_flag), 0);
        chk(exp_q.size() == 0, "R12", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule